// File: doc/BRIEF.md
# Out-of-Order Single-Issue Instruction Selector

This block keeps a small, ordered window of decoded instructions and each cycle chooses at most one of them for the single ALU. The choice is made by scanning the window from the oldest entry and testing each candidate against two register blacklists. One list guards reads and the other guards writes. At the start of every scan both lists equal the mask of destinations that pending loads have reserved. A candidate that loses adds its own registers to the lists, so newer instructions that pass it can never disturb the operands or the result it still needs.

The issued instruction is shown combinationally from the window registers in the same cycle, and it leaves the window at the next clock edge. The younger entries then shift toward the oldest slot. New instructions arrive over a valid/ready handshake, at most one per cycle. A jump closes the window to fetch until the jump itself has been issued. Load/store instructions never overtake one another. Each class is held back while its downstream buffer reports full.

Top module: `ooo_issue_sel`

## Requirements
- R1: After reset the window is empty, `issue_valid` is 0 and `fetch_ready` is 1.
- R2: An instruction is accepted on a clock edge where `fetch_valid` and `fetch_ready` are both 1. `fetch_ready` is 1 only while fewer than 4 entries are held and no jump is held. At most one instruction is accepted per cycle.
- R3: Once a jump (class code 2) is accepted, `fetch_ready` stays 0 until that jump has been issued. A fetch offered meanwhile is dropped.
- R4: A candidate with a valid source register whose bit is set in the read blacklist is not issued. Both blacklists start each cycle equal to `load_rd_mask`, where bit n stands for register n.
- R5: A candidate with a valid destination register whose bit is set in the write blacklist is not issued.
- R6: Candidates are examined oldest first, and the first one that qualifies is issued. It is presented in the same cycle and removed at the next edge, and the remaining entries keep their order.
- R7: A candidate that is passed over sets its destination bit in the read blacklist. It sets its source bits and its destination bit in the write blacklist, before any newer candidate is examined.
- R8: An OP (code 0) or jump (code 2) is not issued while `op_buf_full` is 1. A load/store (code 1) is not issued while `lsu_buf_full` is 1.
- R9: Once a load/store candidate is passed over, no newer load/store is issued in that cycle. Non-memory instructions may still pass it.
- R10: The issued class and register fields equal those that were fetched for that instruction.
- R11: A register field whose valid bit is 0 takes no part in the blacklist tests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_valid | input | 1 | Fetch stream offers an instruction |
| fetch_cls | input | 2 | Class: 0 OP, 1 load/store, 2 jump |
| fetch_rs1_v | input | 1 | First source field is used |
| fetch_rs1 | input | 5 | First source register |
| fetch_rs2_v | input | 1 | Second source field is used |
| fetch_rs2 | input | 5 | Second source register |
| fetch_rd_v | input | 1 | Destination field is used |
| fetch_rd | input | 5 | Destination register |
| fetch_ready | output | 1 | Window accepts an instruction this cycle |
| load_rd_mask | input | 32 | Destinations reserved by pending loads, bit n = register n |
| op_buf_full | input | 1 | OP destination buffer is full |
| lsu_buf_full | input | 1 | Load/store destination buffer is full |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_cls | output | 2 | Class of the issued instruction |
| issue_rs1_v | output | 1 | First source used |
| issue_rs1 | output | 5 | First source register |
| issue_rs2_v | output | 1 | Second source used |
| issue_rs2 | output | 5 | Second source register |
| issue_rd_v | output | 1 | Destination used |
| issue_rd | output | 5 | Destination register |

## Verification
The assertions check several properties on every cycle. An issued instruction never reads a register reserved by a pending load, never writes one, and never goes to a full buffer. The window stays packed from the oldest slot, and an accepted jump drops `fetch_ready` at the next cycle. Only the bench's scenarios show the properties that depend on history. These are the growth of the blacklists behind a skipped instruction, load/store ordering when a younger memory instruction would otherwise qualify, the order that survives a removal, and a fetch that is discarded behind a jump. A long random sweep against an independent window model covers the interleavings that the directed cases miss.

// File: rtl/issue_pkg.sv
package issue_pkg;

  localparam int REG_W = 5;
  localparam int NREG  = 1 << REG_W;

  typedef enum logic [1:0] {
    CLS_OP  = 2'd0,
    CLS_LSU = 2'd1,
    CLS_JMP = 2'd2
  } icls_e;

  typedef struct packed {
    logic             vld;
    icls_e            cls;
    logic             s1_v;
    logic [REG_W-1:0] s1;
    logic             s2_v;
    logic [REG_W-1:0] s2;
    logic             d_v;
    logic [REG_W-1:0] d;
  } slot_t;

endpackage

// File: rtl/issue_window.sv
module issue_window
  import issue_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fetch_valid,
  input  slot_t                 fetch_slot,
  output logic                  fetch_ready,
  input  logic                  drop_en,
  input  logic [IDX_W-1:0]      drop_idx,
  output slot_t [DEPTH-1:0]     win
);

  slot_t [DEPTH-1:0] win_q;
  slot_t [DEPTH-1:0] shifted;
  slot_t [DEPTH-1:0] win_nxt;
  logic  [CNT_W-1:0] cnt;
  logic  [CNT_W-1:0] cnt_after;
  logic              has_jmp;
  logic              take;
  logic              upd_en;

  // occupancy and barrier
  always_comb begin
    cnt     = '0;
    has_jmp = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt = cnt + CNT_W'(win_q[i].vld);
      if (win_q[i].vld && win_q[i].cls == CLS_JMP) has_jmp = 1'b1;
    end
  end

  assign fetch_ready = (cnt < CNT_W'(DEPTH)) && !has_jmp;
  assign take        = fetch_valid && fetch_ready;
  assign cnt_after   = cnt - CNT_W'(drop_en);

  // compaction after removal
  for (genvar j = 0; j < DEPTH; j++) begin : g_shift
    if (j == DEPTH - 1) begin : g_last
      assign shifted[j] = (drop_en && IDX_W'(j) >= drop_idx) ? slot_t'('0) : win_q[j];
    end else begin : g_mid
      assign shifted[j] = (drop_en && IDX_W'(j) >= drop_idx) ? win_q[j+1] : win_q[j];
    end
  end

  // append at the tail
  always_comb begin
    win_nxt = shifted;
    if (take) begin
      win_nxt[cnt_after[IDX_W-1:0]]     = fetch_slot;
      win_nxt[cnt_after[IDX_W-1:0]].vld = 1'b1;
    end
  end

  assign upd_en = drop_en || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (upd_en) begin
      win_q <= win_nxt;
    end
  end

  assign win = win_q;

  // R2
  for (genvar k = 0; k < DEPTH - 1; k++) begin : g_chk
    packed_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_q[k].vld |-> !win_q[k+1].vld);
  end

  // R3
  jmp_barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fetch_slot.cls == CLS_JMP) |=> !fetch_ready);

  // R2
  full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_q[DEPTH-1].vld |-> !fetch_ready);

endmodule

// File: rtl/issue_pick.sv
module issue_pick
  import issue_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_t [DEPTH-1:0] win,
  input  logic [NREG-1:0]   load_mask,
  input  logic              op_full,
  input  logic              lsu_full,
  output logic              pick_valid,
  output logic [IDX_W-1:0]  pick_idx
);

  logic [NREG-1:0] rs_l;
  logic [NREG-1:0] rd_l;
  logic            lsu_hold;
  slot_t           pk;

  always_comb begin
    logic blk;
    logic bfull;
    logic ordr;
    rs_l       = load_mask;
    rd_l       = load_mask;
    lsu_hold   = 1'b0;
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      blk   = 1'b0;
      bfull = 1'b0;
      ordr  = 1'b0;
      if (win[i].vld && !pick_valid) begin
        blk   = (win[i].s1_v && rs_l[win[i].s1]) ||
                (win[i].s2_v && rs_l[win[i].s2]) ||
                (win[i].d_v  && rd_l[win[i].d]);
        bfull = (win[i].cls == CLS_LSU) ? lsu_full : op_full;
        ordr  = (win[i].cls == CLS_LSU) && lsu_hold;
        if (!blk && !bfull && !ordr) begin
          pick_valid = 1'b1;
          pick_idx   = IDX_W'(i);
        end else begin
          if (win[i].d_v) begin
            rs_l[win[i].d] = 1'b1;
            rd_l[win[i].d] = 1'b1;
          end
          if (win[i].s1_v) rd_l[win[i].s1] = 1'b1;
          if (win[i].s2_v) rd_l[win[i].s2] = 1'b1;
          if (win[i].cls == CLS_LSU) lsu_hold = 1'b1;
        end
      end
    end
  end

  assign pk = win[pick_idx];

  // R6
  pick_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> pk.vld);

  // R8
  op_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && pk.cls != CLS_LSU) |-> !op_full);

  // R8
  lsu_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && pk.cls == CLS_LSU) |-> !lsu_full);

  // R4
  src_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> !((pk.s1_v && load_mask[pk.s1]) || (pk.s2_v && load_mask[pk.s2])));

  // R5
  dst_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && pk.d_v) |-> !load_mask[pk.d]);

endmodule

// File: rtl/ooo_issue_sel.sv
module ooo_issue_sel
  import issue_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [1:0]       fetch_cls,
  input  logic             fetch_rs1_v,
  input  logic [REG_W-1:0] fetch_rs1,
  input  logic             fetch_rs2_v,
  input  logic [REG_W-1:0] fetch_rs2,
  input  logic             fetch_rd_v,
  input  logic [REG_W-1:0] fetch_rd,
  output logic             fetch_ready,
  input  logic [NREG-1:0]  load_rd_mask,
  input  logic             op_buf_full,
  input  logic             lsu_buf_full,
  output logic             issue_valid,
  output logic [1:0]       issue_cls,
  output logic             issue_rs1_v,
  output logic [REG_W-1:0] issue_rs1,
  output logic             issue_rs2_v,
  output logic [REG_W-1:0] issue_rs2,
  output logic             issue_rd_v,
  output logic [REG_W-1:0] issue_rd
);

  slot_t             fslot;
  slot_t [DEPTH-1:0] win;
  slot_t             sel;
  logic              pick_valid;
  logic [IDX_W-1:0]  pick_idx;

  always_comb begin
    fslot      = '0;
    fslot.vld  = 1'b1;
    fslot.cls  = icls_e'(fetch_cls);
    fslot.s1_v = fetch_rs1_v;
    fslot.s1   = fetch_rs1;
    fslot.s2_v = fetch_rs2_v;
    fslot.s2   = fetch_rs2;
    fslot.d_v  = fetch_rd_v;
    fslot.d    = fetch_rd;
  end

  issue_window #(.DEPTH(DEPTH)) window_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_slot  (fslot),
    .fetch_ready (fetch_ready),
    .drop_en     (pick_valid),
    .drop_idx    (pick_idx),
    .win         (win)
  );

  issue_pick #(.DEPTH(DEPTH)) pick_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .win        (win),
    .load_mask  (load_rd_mask),
    .op_full    (op_buf_full),
    .lsu_full   (lsu_buf_full),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx)
  );

  assign sel         = win[pick_idx];
  assign issue_valid = pick_valid;
  assign issue_cls   = sel.cls;
  assign issue_rs1_v = sel.s1_v;
  assign issue_rs1   = sel.s1;
  assign issue_rs2_v = sel.s2_v;
  assign issue_rs2   = sel.s2;
  assign issue_rd_v  = sel.d_v;
  assign issue_rd    = sel.d;

  // R1
  no_issue_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win[0].vld |-> !issue_valid);

endmodule

// File: tb/ooo_issue_sel_tb_top.sv
module ooo_issue_sel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [1:0]  fetch_cls;
  logic        fetch_rs1_v, fetch_rs2_v, fetch_rd_v;
  logic [4:0]  fetch_rs1, fetch_rs2, fetch_rd;
  logic        fetch_ready;
  logic [31:0] load_rd_mask;
  logic        op_buf_full, lsu_buf_full;
  logic        issue_valid;
  logic [1:0]  issue_cls;
  logic        issue_rs1_v, issue_rs2_v, issue_rd_v;
  logic [4:0]  issue_rs1, issue_rs2, issue_rd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  ooo_issue_sel dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_cls(fetch_cls),
    .fetch_rs1_v(fetch_rs1_v), .fetch_rs1(fetch_rs1), .fetch_rs2_v(fetch_rs2_v),
    .fetch_rs2(fetch_rs2), .fetch_rd_v(fetch_rd_v), .fetch_rd(fetch_rd),
    .fetch_ready(fetch_ready), .load_rd_mask(load_rd_mask),
    .op_buf_full(op_buf_full), .lsu_buf_full(lsu_buf_full),
    .issue_valid(issue_valid), .issue_cls(issue_cls),
    .issue_rs1_v(issue_rs1_v), .issue_rs1(issue_rs1),
    .issue_rs2_v(issue_rs2_v), .issue_rs2(issue_rs2),
    .issue_rd_v(issue_rd_v), .issue_rd(issue_rd)
  );

  // bench-side window model: packed key {cls,s1v,s1,s2v,s2,dv,d}
  int m_cnt = 0;
  int m_key [4];

  function automatic int mk(int c, int a_v, int a, int b_v, int b, int dv, int d);
    return (c << 18) | (a_v << 17) | (a << 12) | (b_v << 11) | (b << 6) | (dv << 5) | d;
  endfunction

  function automatic void model_pick(input logic [31:0] lm, input bit opf, input bit lsf,
                                     output bit ok, output int idx);
    logic [31:0] rs, rd;
    bit hold;
    rs = lm; rd = lm; hold = 0; ok = 0; idx = 0;
    for (int i = 0; i < m_cnt; i++) begin
      int c, av, a, bv, b, dv, d;
      bit bad;
      c  = (m_key[i] >> 18) & 3;
      av = (m_key[i] >> 17) & 1;  a = (m_key[i] >> 12) & 31;
      bv = (m_key[i] >> 11) & 1;  b = (m_key[i] >> 6) & 31;
      dv = (m_key[i] >> 5) & 1;   d = m_key[i] & 31;
      bad = (av == 1 && rs[a]) || (bv == 1 && rs[b]) || (dv == 1 && rd[d]) ||
            (c == 1 ? lsf : opf) || (c == 1 && hold);
      if (!bad) begin ok = 1; idx = i; return; end
      if (dv == 1) begin rs[d] = 1'b1; rd[d] = 1'b1; end
      if (av == 1) rd[a] = 1'b1;
      if (bv == 1) rd[b] = 1'b1;
      if (c == 1) hold = 1;
    end
  endfunction

  function automatic int dut_key();
    return mk(int'(issue_cls), int'(issue_rs1_v), int'(issue_rs1), int'(issue_rs2_v),
              int'(issue_rs2), int'(issue_rd_v), int'(issue_rd));
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic push(int c, int av, int a, int bv, int b, int dv, int d);
    fetch_cls = 2'(c); fetch_rs1_v = 1'(av); fetch_rs1 = 5'(a);
    fetch_rs2_v = 1'(bv); fetch_rs2 = 5'(b); fetch_rd_v = 1'(dv); fetch_rd = 5'(d);
    fetch_valid = 1'b1;
    tick();
    fetch_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fetch_valid = 0; fetch_cls = 0; fetch_rs1_v = 0; fetch_rs1 = 0;
    fetch_rs2_v = 0; fetch_rs2 = 0; fetch_rd_v = 0; fetch_rd = 0;
    load_rd_mask = 0; op_buf_full = 0; lsu_buf_full = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 issue_valid", issue_valid, 0);
    chk("R1 fetch_ready", fetch_ready, 1);

    // skipped instruction widens blacklists (R2, R4, R5, R7, R8)
    load_rd_mask = 32'h6; op_buf_full = 1;
    push(0, 1, 2, 1, 3, 1, 4);
    push(0, 1, 4, 0, 0, 1, 5);
    push(0, 1, 6, 0, 0, 1, 3);
    push(0, 1, 7, 0, 0, 1, 8);
    chk("R2 full window ready", fetch_ready, 0);
    chk("R8 op full holds", issue_valid, 0);
    op_buf_full = 0; #1;
    chk("R7 only clear one issues", issue_valid, 1);
    chk("R7 issued rd", issue_rd, 8);
    tick();
    chk("R7 rest blocked", issue_valid, 0);
    chk("R4 rest blocked by load", issue_valid, 0);
    chk("R2 slot freed", fetch_ready, 1);
    load_rd_mask = 0; #1;
    chk("R6 oldest first", issue_rd, 4);
    tick();
    chk("R6 order kept 2nd", issue_rd, 5);
    tick();
    chk("R6 order kept 3rd", issue_rd, 3);
    tick();
    chk("R6 drained", issue_valid, 0);

    // destination reserved by load (R5)
    load_rd_mask = 32'h1 << 9;
    push(0, 0, 0, 0, 0, 1, 9);
    chk("R5 dest reserved", issue_valid, 0);
    push(0, 0, 0, 0, 0, 1, 10);
    chk("R5 younger passes", issue_rd, 10);
    tick();
    chk("R5 still held", issue_valid, 0);
    load_rd_mask = 0; #1;
    chk("R5 released", issue_rd, 9);
    tick();

    // invalid fields ignored (R11)
    load_rd_mask = 32'h1 << 12;
    push(0, 0, 12, 0, 12, 1, 13);
    chk("R11 invalid src ignored", issue_valid, 1);
    chk("R11 rd", issue_rd, 13);
    tick();
    load_rd_mask = 0;

    // memory order (R9)
    load_rd_mask = 32'h2; op_buf_full = 1;
    push(1, 1, 1, 0, 0, 1, 14);
    push(1, 1, 15, 0, 0, 1, 16);
    push(0, 1, 17, 0, 0, 1, 18);
    chk("R9 younger lsu held", issue_valid, 0);
    op_buf_full = 0; #1;
    chk("R9 op passes lsu", issue_rd, 18);
    tick();
    chk("R9 lsu stays ordered", issue_valid, 0);
    load_rd_mask = 0; #1;
    chk("R9 first lsu", issue_rd, 14);
    tick();
    chk("R9 second lsu", issue_rd, 16);
    chk("R10 class lsu", issue_cls, 1);
    tick();

    // lsu buffer full and field passthrough (R8, R10)
    lsu_buf_full = 1;
    push(1, 1, 20, 1, 21, 1, 19);
    chk("R8 lsu full holds", issue_valid, 0);
    lsu_buf_full = 0; #1;
    chk("R10 key", dut_key(), mk(1, 1, 20, 1, 21, 1, 19));
    tick();

    // jump barrier (R3)
    op_buf_full = 1;
    push(2, 0, 0, 0, 0, 0, 0);
    chk("R3 ready low", fetch_ready, 0);
    push(0, 0, 0, 0, 0, 1, 20);
    op_buf_full = 0; #1;
    chk("R3 jump issues", issue_cls, 2);
    tick();
    chk("R3 dropped fetch", issue_valid, 0);
    chk("R3 ready back", fetch_ready, 1);

    // random sweep against the model (R6)
    m_cnt = 0;
    for (int it = 0; it < 4000; it++) begin
      bit ok, acc, exp_rdy;
      int idx, r, key;
      r = $urandom;
      fetch_valid = (r & 3) != 0;
      fetch_cls = ((r >> 2) & 7) == 0 ? 2'd2 : (((r >> 5) & 1) ? 2'd1 : 2'd0);
      fetch_rs1_v = r[8]; fetch_rs1 = 5'((r >> 9) & 7);
      fetch_rs2_v = r[12]; fetch_rs2 = 5'((r >> 13) & 7);
      fetch_rd_v = r[16] | r[17]; fetch_rd = 5'((r >> 18) & 7);
      op_buf_full = ((r >> 21) & 3) == 0;
      lsu_buf_full = ((r >> 23) & 3) == 0;
      load_rd_mask = $urandom & $urandom & 32'hff;
      #1;
      key = mk(int'(fetch_cls), int'(fetch_rs1_v), int'(fetch_rs1), int'(fetch_rs2_v),
               int'(fetch_rs2), int'(fetch_rd_v), int'(fetch_rd));
      exp_rdy = m_cnt < 4;
      for (int i = 0; i < m_cnt; i++) if (((m_key[i] >> 18) & 3) == 2) exp_rdy = 0;
      model_pick(load_rd_mask, op_buf_full, lsu_buf_full, ok, idx);
      chk("R6 sweep valid", issue_valid, ok);
      chk("R2 sweep ready", fetch_ready, exp_rdy);
      if (ok) chk("R6 sweep key", dut_key(), m_key[idx]);
      acc = fetch_valid && exp_rdy;
      tick();
      if (ok) begin
        for (int j = idx; j < m_cnt - 1; j++) m_key[j] = m_key[j+1];
        m_cnt--;
      end
      if (acc) begin m_key[m_cnt] = key; m_cnt++; end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule